// File: doc/BRIEF.md
# Command Stream Word Decoder

This block sits between a word fetcher and a method queue. It takes 32-bit command-stream words, one per valid/ready handshake, and decides what each word means. It does this from a three-phase state machine: waiting for a header, waiting for a length word, or consuming data words. A header word can open a method burst (increasing, non-increasing, or long non-increasing with a separate length word). It can also redirect the fetcher (legacy jump, jump, call, return) or update a per-card acceptance flag (mask conditional). Each data word of a burst leaves the block as a (subchannel, method, data) tuple on a registered output with its own valid/ready handshake.

The fetch side supplies `next_get`, the read address that follows the word being offered. A call keeps that address as its return point. Redirects and errors are one-cycle pulses in the cycle after the word that caused them is accepted. The block never reads memory, and it does not execute methods.

Top module: `cmd_word_decoder`

## Requirements
- R1: After reset the decoder waits for a header word, out_valid, redirect_valid and err_valid are low, in_ready is high, no subroutine is active and the conditional acceptance flag is set.
- R2: A header with (w & 0xE0030003)==0 opens an increasing burst. Its method index is w[12:2], subchannel w[15:13] and count w[28:18]. Each of the following count words is emitted with the method index one higher than the word before, wrapping from 0x7FF to 0.
- R3: A header with (w & 0xE0030003)==0x40000000 opens a non-increasing burst with the same field positions, and every data word of it goes to the header's method index.
- R4: A header with (w & 0xFFFF0003)==0x00030000 is legal only while ring_mode is 1. It opens a non-increasing burst whose count is the low 24 bits of the next word. A zero count there returns the decoder to waiting for a header. While ring_mode is 0 such a header raises error 4.
- R5: A burst header with count zero emits nothing, and the next word is decoded as a header.
- R6: While ring_mode is 0, (w & 0xE0000003)==0x20000000 pulses redirect_valid with address w & 0x1FFFFFFF. A word with w[1:0]==01 pulses it with w & 0xFFFFFFFC. While ring_mode is 1 both forms raise error 4.
- R7: A word with w[1:0]==10 (ring_mode 0) is a call. If a subroutine is already active it raises error 1. Otherwise it records next_get as the return address, marks a subroutine active and redirects to w & 0xFFFFFFFC.
- R8: The word 0x00020000 (ring_mode 0) is a return. If no subroutine is active it raises error 3. Otherwise it redirects to the recorded return address and clears the active mark.
- R9: While cond_enable is 1, (w & 0xFFFF0003)==0x00010000 sets the acceptance flag to |(w[15:4] & card_mask). While cond_enable is 0 the word raises error 4.
- R10: While cond_enable is 1 and the acceptance flag is clear, data words are consumed but not emitted. While cond_enable is 0 the flag has no effect.
- R11: A data word whose method index is below 64 and whose bit in low_mthd_ok is 0 raises error 2. The word is not emitted, the burst ends and the next word is decoded as a header.
- R12: A header matching no legal form raises error 4, is consumed, and leaves the decoder waiting for a header. Error codes are 3 bits wide: 1 call-while-active, 2 bad low method, 3 return-while-inactive, 4 bad header.
- R13: While out_valid is high and out_ready is low, in_ready is low and out_subc, out_mthd and out_data hold. No word is lost or repeated across the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_mode | input | 1 | 1 selects ring-descriptor mode (long bursts legal, flow control illegal) |
| cond_enable | input | 1 | Enables the mask conditional header and gating |
| card_mask | input | 12 | Local mask ANDed with the conditional's mask field |
| low_mthd_ok | input | 64 | One bit per method index below 64; 1 accepts it |
| next_get | input | 32 | Read address following the offered word |
| in_valid | input | 1 | Offered word is valid |
| in_word | input | 32 | Command-stream word |
| in_ready | output | 1 | Decoder accepts the word this cycle |
| out_valid | output | 1 | Method tuple valid |
| out_ready | input | 1 | Downstream accepts the tuple |
| out_subc | output | 3 | Subchannel |
| out_mthd | output | 11 | Method index |
| out_data | output | 32 | Method data |
| redirect_valid | output | 1 | One-cycle pulse: fetcher must continue at redirect_addr |
| redirect_addr | output | 32 | New read address |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Error type (see R12) |

## Verification
The bench targets header words that differ from a legal form by only a few bits: low bits 11, a long header outside ring mode, a return with no active subroutine, and a conditional with the feature off. A decoder that ordered its matches wrongly would treat these as bursts or redirects and emit no error. It checks the increasing method index across the 0x7FF wrap and zero-count headers, where an off-by-one counter would swallow the following header or emit a stray tuple. The return after a call is driven with a changed next_get, so a design that redirected to the live address instead of the recorded one gives the wrong address. A bad low method in mid-burst must end the burst, and a stalled output must hold its tuple without dropping the waiting word.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  typedef enum logic [3:0] {
    HK_INC, HK_NONINC, HK_LONG, HK_JMP_OLD, HK_JMP,
    HK_CALL, HK_RET, HK_COND, HK_BAD
  } hdr_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_LEN, PH_DATA
  } phase_e;

  localparam logic [2:0] ERR_CALL_BUSY = 3'd1;
  localparam logic [2:0] ERR_LOW_MTHD  = 3'd2;
  localparam logic [2:0] ERR_RET_IDLE  = 3'd3;
  localparam logic [2:0] ERR_BAD_HDR   = 3'd4;

  localparam logic [31:0] RET_WORD = 32'h0002_0000;

  // Header classification, first match wins.
  function automatic hdr_kind_e f_classify(input logic [31:0] w,
                                           input logic ring,
                                           input logic cond_en);
    hdr_kind_e k;
    k = HK_BAD;
    if (!ring && (w & 32'hE000_0003) == 32'h2000_0000)       k = HK_JMP_OLD;
    else if (!ring && w[1:0] == 2'b01)                        k = HK_JMP;
    else if (!ring && w[1:0] == 2'b10)                        k = HK_CALL;
    else if (!ring && w == RET_WORD)                          k = HK_RET;
    else if ((w & 32'hE003_0003) == 32'h0000_0000)            k = HK_INC;
    else if ((w & 32'hE003_0003) == 32'h4000_0000)            k = HK_NONINC;
    else if (ring && (w & 32'hFFFF_0003) == 32'h0003_0000)    k = HK_LONG;
    else if (cond_en && (w & 32'hFFFF_0003) == 32'h0001_0000) k = HK_COND;
    return k;
  endfunction

  function automatic logic [31:0] f_target(input logic [31:0] w, input logic legacy);
    return legacy ? (w & 32'h1FFF_FFFF) : (w & 32'hFFFF_FFFC);
  endfunction

  function automatic logic f_cond_hit(input logic [31:0] w, input logic [11:0] mask);
    return |(w[15:4] & mask);
  endfunction

endpackage

// File: rtl/cmd_hdr_classify.sv
module cmd_hdr_classify
  import cmd_dec_pkg::*;
#(
  parameter int MTHD_W = 11,
  parameter int SUBC_W = 3,
  parameter int HCNT_W = 11,
  parameter int MASK_W = 12
) (
  input  logic [31:0]       word,
  input  logic              ring_mode,
  input  logic              cond_enable,
  input  logic [MASK_W-1:0] card_mask,
  output hdr_kind_e         kind,
  output logic [MTHD_W-1:0] f_mthd,
  output logic [SUBC_W-1:0] f_subc,
  output logic [HCNT_W-1:0] f_cnt,
  output logic [31:0]       f_addr,
  output logic              f_hit
);
  localparam int SUBC_LO = 2 + MTHD_W;
  localparam int CNT_LO  = SUBC_LO + SUBC_W + 2;

  always_comb begin
    kind   = f_classify(word, ring_mode, cond_enable);
    f_mthd = word[2 +: MTHD_W];
    f_subc = word[SUBC_LO +: SUBC_W];
    f_cnt  = word[CNT_LO +: HCNT_W];
    f_addr = f_target(word, kind == HK_JMP_OLD);
    f_hit  = f_cond_hit(word, 12'(card_mask));
  end
endmodule

// File: rtl/cmd_mthd_gate.sv
module cmd_mthd_gate #(
  parameter int MTHD_W = 11,
  parameter int LOW_N  = 64
) (
  input  logic [MTHD_W-1:0] mthd,
  input  logic [LOW_N-1:0]  low_ok,
  input  logic              cond_enable,
  input  logic              cond_flag,
  output logic              mthd_bad,
  output logic              drop
);
  localparam int LIDX_W = $clog2(LOW_N);

  always_comb begin
    mthd_bad = (int'(mthd) < LOW_N) && !low_ok[mthd[LIDX_W-1:0]];
    drop     = cond_enable && !cond_flag;
  end
endmodule

// File: rtl/cmd_emit_stage.sv
module cmd_emit_stage #(
  parameter int MTHD_W = 11,
  parameter int SUBC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SUBC_W-1:0] ld_subc,
  input  logic [MTHD_W-1:0] ld_mthd,
  input  logic [31:0]       ld_data,
  input  logic              out_ready,
  output logic              room,
  output logic              out_valid,
  output logic [SUBC_W-1:0] out_subc,
  output logic [MTHD_W-1:0] out_mthd,
  output logic [31:0]       out_data
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_subc  <= '0;
      out_mthd  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_subc  <= ld_subc;
      out_mthd  <= ld_mthd;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
  import cmd_dec_pkg::*;
#(
  parameter int MTHD_W = 11,
  parameter int SUBC_W = 3,
  parameter int HCNT_W = 11,
  parameter int LCNT_W = 24,
  parameter int MASK_W = 12,
  parameter int LOW_N  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_mode,
  input  logic              cond_enable,
  input  logic [MASK_W-1:0] card_mask,
  input  logic [LOW_N-1:0]  low_mthd_ok,
  input  logic [31:0]       next_get,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SUBC_W-1:0] out_subc,
  output logic [MTHD_W-1:0] out_mthd,
  output logic [31:0]       out_data,
  output logic              redirect_valid,
  output logic [31:0]       redirect_addr,
  output logic              err_valid,
  output logic [2:0]        err_code
);
  localparam logic [LCNT_W-1:0] CNT_ONE = LCNT_W'(1);

  phase_e            phase;
  logic [MTHD_W-1:0] cur_mthd;
  logic [SUBC_W-1:0] cur_subc;
  logic [LCNT_W-1:0] cur_cnt;
  logic              cur_incr;
  logic              sub_active;
  logic [31:0]       sub_ret;
  logic              cond_flag;

  hdr_kind_e         h_kind;
  logic [MTHD_W-1:0] h_mthd;
  logic [SUBC_W-1:0] h_subc;
  logic [HCNT_W-1:0] h_cnt;
  logic [31:0]       h_addr;
  logic              h_hit;
  logic              g_bad;
  logic              g_drop;
  logic              room;

  // Named internal events.
  logic acc, ev_hdr, ev_len, ev_dat, ev_emit, ev_mbad;

  assign in_ready = room;
  assign acc      = in_valid && in_ready;
  assign ev_hdr   = acc && phase == PH_IDLE;
  assign ev_len   = acc && phase == PH_LEN;
  assign ev_dat   = acc && phase == PH_DATA;
  assign ev_mbad  = ev_dat && g_bad;
  assign ev_emit  = ev_dat && !g_bad && !g_drop;

  cmd_hdr_classify #(
    .MTHD_W(MTHD_W), .SUBC_W(SUBC_W), .HCNT_W(HCNT_W), .MASK_W(MASK_W)
  ) u_cls (
    .word(in_word), .ring_mode(ring_mode), .cond_enable(cond_enable),
    .card_mask(card_mask), .kind(h_kind), .f_mthd(h_mthd), .f_subc(h_subc),
    .f_cnt(h_cnt), .f_addr(h_addr), .f_hit(h_hit)
  );

  cmd_mthd_gate #(.MTHD_W(MTHD_W), .LOW_N(LOW_N)) u_gate (
    .mthd(cur_mthd), .low_ok(low_mthd_ok), .cond_enable(cond_enable),
    .cond_flag(cond_flag), .mthd_bad(g_bad), .drop(g_drop)
  );

  cmd_emit_stage #(.MTHD_W(MTHD_W), .SUBC_W(SUBC_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(ev_emit), .ld_subc(cur_subc),
    .ld_mthd(cur_mthd), .ld_data(in_word), .out_ready(out_ready),
    .room(room), .out_valid(out_valid), .out_subc(out_subc),
    .out_mthd(out_mthd), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase          <= PH_IDLE;
      cur_mthd       <= '0;
      cur_subc       <= '0;
      cur_cnt        <= '0;
      cur_incr       <= 1'b0;
      sub_active     <= 1'b0;
      sub_ret        <= '0;
      cond_flag      <= 1'b1;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
      err_valid      <= 1'b0;
      err_code       <= '0;
    end else begin
      redirect_valid <= 1'b0;
      err_valid      <= 1'b0;
      if (ev_hdr) begin
        unique case (h_kind)
          HK_INC, HK_NONINC: begin
            cur_mthd <= h_mthd;
            cur_subc <= h_subc;
            cur_cnt  <= LCNT_W'(h_cnt);
            cur_incr <= (h_kind == HK_INC);
            phase    <= (h_cnt != '0) ? PH_DATA : PH_IDLE;
          end
          HK_LONG: begin
            cur_mthd <= h_mthd;
            cur_subc <= h_subc;
            cur_incr <= 1'b0;
            phase    <= PH_LEN;
          end
          HK_JMP_OLD, HK_JMP: begin
            redirect_valid <= 1'b1;
            redirect_addr  <= h_addr;
          end
          HK_CALL: begin
            if (sub_active) begin
              err_valid <= 1'b1;
              err_code  <= ERR_CALL_BUSY;
            end else begin
              sub_active     <= 1'b1;
              sub_ret        <= next_get;
              redirect_valid <= 1'b1;
              redirect_addr  <= h_addr;
            end
          end
          HK_RET: begin
            if (!sub_active) begin
              err_valid <= 1'b1;
              err_code  <= ERR_RET_IDLE;
            end else begin
              sub_active     <= 1'b0;
              redirect_valid <= 1'b1;
              redirect_addr  <= sub_ret;
            end
          end
          HK_COND: cond_flag <= h_hit;
          default: begin
            err_valid <= 1'b1;
            err_code  <= ERR_BAD_HDR;
          end
        endcase
      end else if (ev_len) begin
        cur_cnt <= in_word[LCNT_W-1:0];
        phase   <= (in_word[LCNT_W-1:0] != '0) ? PH_DATA : PH_IDLE;
      end else if (ev_dat) begin
        if (g_bad) begin
          err_valid <= 1'b1;
          err_code  <= ERR_LOW_MTHD;
          cur_cnt   <= '0;
          phase     <= PH_IDLE;
        end else begin
          cur_cnt <= cur_cnt - CNT_ONE;
          if (cur_incr) cur_mthd <= cur_mthd + 1'b1;
          if (cur_cnt == CNT_ONE) phase <= PH_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_word_decoder_chk.sv
module cmd_word_decoder_chk #(
  parameter int MTHD_W = 11,
  parameter int SUBC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SUBC_W-1:0] out_subc,
  input logic [MTHD_W-1:0] out_mthd,
  input logic [31:0]       out_data,
  input logic              redirect_valid,
  input logic              err_valid,
  input logic [2:0]        err_code,
  input logic              ev_emit,
  input logic              ev_mbad,
  input logic              sub_active
);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                               && $stable(out_mthd) && $stable(out_subc));

  a_r13_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r12_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code >= 3'd1 && err_code <= 3'd4));

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_valid && redirect_valid));

  a_r2_emit_shows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_emit |=> out_valid);

  a_r11_bad_reports: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mbad |=> err_valid && err_code == 3'd2);

  a_r7_call_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_active) |-> redirect_valid);

  a_r8_ret_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sub_active) |-> redirect_valid);
endmodule

bind cmd_word_decoder cmd_word_decoder_chk #(.MTHD_W(MTHD_W), .SUBC_W(SUBC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_subc(out_subc), .out_mthd(out_mthd),
  .out_data(out_data), .redirect_valid(redirect_valid), .err_valid(err_valid),
  .err_code(err_code), .ev_emit(ev_emit), .ev_mbad(ev_mbad),
  .sub_active(sub_active)
);

// File: tb/cmd_word_decoder_tb.sv
module cmd_word_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring_mode = 1'b0;
  logic        cond_enable = 1'b1;
  logic [11:0] card_mask = 12'h00F;
  logic [63:0] low_mthd_ok = 64'h1;
  logic [31:0] next_get = 32'h1000;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_subc;
  logic [10:0] out_mthd;
  logic [31:0] out_data;
  logic        redirect_valid;
  logic [31:0] redirect_addr;
  logic        err_valid;
  logic [2:0]  err_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_word_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ring_mode(ring_mode), .cond_enable(cond_enable),
    .card_mask(card_mask), .low_mthd_ok(low_mthd_ok), .next_get(next_get),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_subc(out_subc),
    .out_mthd(out_mthd), .out_data(out_data), .redirect_valid(redirect_valid),
    .redirect_addr(redirect_addr), .err_valid(err_valid), .err_code(err_code)
  );

  // kind: 0 nothing, 1 tuple, 2 redirect, 3 error
  // fields: {word, kind, value, mthd, subc, req}
  localparam int NV = 33;
  localparam logic [83:0] VEC [NV] = '{
    {32'h0008_6100, 2'd0, 32'h0,         11'h000, 3'd0, 4'd2},  // R2 header
    {32'hAAAA_0001, 2'd1, 32'hAAAA_0001, 11'h040, 3'd3, 4'd2},  // R2
    {32'hAAAA_0002, 2'd1, 32'hAAAA_0002, 11'h041, 3'd3, 4'd2},  // R2
    {32'h4008_2140, 2'd0, 32'h0,         11'h000, 3'd0, 4'd3},  // R3 header
    {32'h0000_0011, 2'd1, 32'h11,        11'h050, 3'd1, 4'd3},  // R3
    {32'h0000_0022, 2'd1, 32'h22,        11'h050, 3'd1, 4'd3},  // R3
    {32'h2000_1230, 2'd2, 32'h0000_1230, 11'h000, 3'd0, 4'd6},  // R6 legacy
    {32'h0000_4561, 2'd2, 32'h0000_4560, 11'h000, 3'd0, 4'd6},  // R6
    {32'h0002_0000, 2'd3, 32'd3,         11'h000, 3'd0, 4'd8},  // R8 inactive
    {32'h0000_8002, 2'd2, 32'h0000_8000, 11'h000, 3'd0, 4'd7},  // R7 call
    {32'h0000_9002, 2'd3, 32'd1,         11'h000, 3'd0, 4'd7},  // R7 nested
    {32'h0002_0000, 2'd2, 32'h0000_1024, 11'h000, 3'd0, 4'd8},  // R8 saved get
    {32'h0000_0003, 2'd3, 32'd4,         11'h000, 3'd0, 4'd12}, // R12
    {32'h0003_0000, 2'd3, 32'd4,         11'h000, 3'd0, 4'd4},  // R4 ring off
    {32'h0001_0F00, 2'd0, 32'h0,         11'h000, 3'd0, 4'd9},  // R9 miss
    {32'h0004_0100, 2'd0, 32'h0,         11'h000, 3'd0, 4'd10}, // R10
    {32'h0000_0033, 2'd0, 32'h0,         11'h000, 3'd0, 4'd10}, // R10 dropped
    {32'h0001_0010, 2'd0, 32'h0,         11'h000, 3'd0, 4'd9},  // R9 hit
    {32'h0004_0104, 2'd0, 32'h0,         11'h000, 3'd0, 4'd9},  // R9
    {32'h0000_0044, 2'd1, 32'h44,        11'h041, 3'd0, 4'd9},  // R9
    {32'h0008_0014, 2'd0, 32'h0,         11'h000, 3'd0, 4'd11}, // R11
    {32'h0000_0055, 2'd3, 32'd2,         11'h000, 3'd0, 4'd11}, // R11 bad
    {32'h0004_0000, 2'd0, 32'h0,         11'h000, 3'd0, 4'd11}, // R11 header
    {32'h0000_0066, 2'd1, 32'h66,        11'h000, 3'd0, 4'd11}, // R11 ok
    {32'h0000_0100, 2'd0, 32'h0,         11'h000, 3'd0, 4'd5},  // R5
    {32'h4004_FFFC, 2'd0, 32'h0,         11'h000, 3'd0, 4'd3},  // R3
    {32'h0000_0077, 2'd1, 32'h77,        11'h7FF, 3'd7, 4'd3},  // R3
    {32'h0008_1FFC, 2'd0, 32'h0,         11'h000, 3'd0, 4'd2},  // R2 wrap
    {32'h0000_0088, 2'd1, 32'h88,        11'h7FF, 3'd0, 4'd2},  // R2
    {32'h0000_0099, 2'd1, 32'h99,        11'h000, 3'd0, 4'd2},  // R2
    {32'h0000_0000, 2'd0, 32'h0,         11'h000, 3'd0, 4'd5},  // R5
    {32'h4000_0000, 2'd0, 32'h0,         11'h000, 3'd0, 4'd5},  // R5
    {32'h2000_0000, 2'd2, 32'h0,         11'h000, 3'd0, 4'd5}   // R5 header
  };

  task automatic chk(input string req, input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Compares all outputs against one expected outcome.
  task automatic expect_out(input string req, input logic [1:0] kind,
                            input logic [31:0] val, input logic [10:0] m,
                            input logic [2:0] s);
    logic [3:0] act_f, exp_f;
    act_f = {out_valid, redirect_valid, err_valid, 1'b0};
    exp_f = {kind == 2'd1, kind == 2'd2, kind == 2'd3, 1'b0};
    if (act_f != exp_f)
      chk(req, 1'b0, "flags", 32'(act_f), 32'(exp_f));
    else if (kind == 2'd1)
      chk(req, out_data == val && out_mthd == m && out_subc == s, "tuple",
          {out_data[15:0], 2'b0, out_mthd, out_subc}, {val[15:0], 2'b0, m, s});
    else if (kind == 2'd2)
      chk(req, redirect_addr == val, "redirect", redirect_addr, val);
    else if (kind == 2'd3)
      chk(req, 32'(err_code) == val, "error", 32'(err_code), val);
    else
      chk(req, 1'b1, "idle", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", !out_valid && !redirect_valid && !err_valid && in_ready, "reset",
        {out_valid, redirect_valid, err_valid, in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      next_get = 32'h1000 + 32'(i * 4);
      push(VEC[i][83:52]);
      expect_out($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][51:50],
                 VEC[i][49:18], VEC[i][17:7], VEC[i][6:4]);
    end

    // R6 / R4: ring mode
    ring_mode = 1'b1;
    push(32'h0000_4561);  expect_out("R6 ring jump", 2'd3, 32'd4, 0, 0);
    push(32'h0002_0000);  expect_out("R8 ring return", 2'd3, 32'd4, 0, 0);
    push(32'h0003_4180);  expect_out("R4 long hdr", 2'd0, 0, 0, 0);
    push(32'hFF00_0002);  expect_out("R4 len", 2'd0, 0, 0, 0);
    push(32'h0000_00D1);  expect_out("R4 data1", 2'd1, 32'hD1, 11'h060, 3'd2);
    push(32'h0000_00D2);  expect_out("R4 data2", 2'd1, 32'hD2, 11'h060, 3'd2);
    push(32'h0003_4180);  expect_out("R4 long hdr2", 2'd0, 0, 0, 0);
    push(32'h0100_0000);  expect_out("R4 len zero", 2'd0, 0, 0, 0);
    push(32'h0004_0104);  expect_out("R4 next hdr", 2'd0, 0, 0, 0);
    push(32'h0000_00E1);  expect_out("R4 after zero", 2'd1, 32'hE1, 11'h041, 3'd0);
    ring_mode = 1'b0;

    // R9: conditional with feature off
    cond_enable = 1'b0;
    push(32'h0001_0010);  expect_out("R9 cond off", 2'd3, 32'd4, 0, 0);

    // R10: flag clear but gating disabled
    cond_enable = 1'b1;
    push(32'h0001_0F00);  expect_out("R10 clear flag", 2'd0, 0, 0, 0);
    cond_enable = 1'b0;
    push(32'h0004_0100);  expect_out("R10 hdr", 2'd0, 0, 0, 0);
    push(32'h0000_00C1);  expect_out("R10 not gated", 2'd1, 32'hC1, 11'h040, 3'd0);
    cond_enable = 1'b1;
    push(32'h0001_0010);  expect_out("R9 set flag", 2'd0, 0, 0, 0);

    // R13: downstream stall
    out_ready = 1'b0;
    push(32'h0008_0100);  expect_out("R13 hdr", 2'd0, 0, 0, 0);
    push(32'h0000_00B1);  expect_out("R13 first", 2'd1, 32'hB1, 11'h040, 3'd0);
    in_valid = 1'b1;
    in_word  = 32'h0000_00B2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R13", !in_ready && out_valid && out_data == 32'hB1, "stall hold",
          out_data, 32'hB1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R13 second", 2'd1, 32'hB2, 11'h041, 3'd0);
    @(negedge clk);
    chk("R13", !out_valid && !err_valid, "drained", 32'(out_valid), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule